// File: doc/BRIEF.md
# Load-use hazard stall controller

This block sits in the decode stage of a five-stage in-order pipeline. It looks at the instruction now in execute. If that instruction is a load, and its destination register is one of the two source registers of the instruction in decode, the result cannot reach the consumer in time. The block then asks for a single-cycle stall.

While the stall is active, it drops the write enables of the program counter and of the fetch/decode pipeline register, so both keep their contents. It also raises a select that loads zeros into the control fields written into the decode/execute register. That slot then travels down the pipe as a no-op. The load and every instruction ahead of it keep moving.

One cycle later the no-op sits in execute with its read flag clear. The request drops by itself and the held instruction goes on. Forwarding, which lies outside this block, covers the rest of the dependency. The block is purely combinational and its outputs settle within the same cycle.

Top module: `lu_hazard_unit`

## Requirements
- R1: With `ex_mem_read_i`=1 and `ex_rt_i` equal to `id_rs_i`, a stall is requested: `pc_we_o`=0, `ifid_we_o`=0, `ctrl_zero_o`=1.
- R2: With `ex_mem_read_i`=1 and `ex_rt_i` equal to `id_rt_i`, a stall is requested, with the same output values as in R1.
- R3: With `ex_mem_read_i`=0, no stall is requested for any register values: `pc_we_o`=1, `ifid_we_o`=1, `ctrl_zero_o`=0.
- R4: With `ex_mem_read_i`=1 and `ex_rt_i` equal to neither decode source, no stall is requested, with the same output values as in R3.
- R5: `pc_we_o` and `ifid_we_o` are always equal, and both are 0 exactly when a stall is requested.
- R6: `ctrl_zero_o`=1 selects all-zero control fields into decode/execute, and `ctrl_zero_o`=0 passes the real control fields. `ctrl_zero_o` is always the inverse of `pc_we_o`.
- R7: In a pipeline that loads a zeroed bubble with a clear read flag when `ctrl_zero_o`=1, a load followed directly by a dependent instruction gets exactly one bubble. A dependent instruction two slots behind the load, or an independent one, gets none.
- R8: Register index 0 is compared like any other index. A load targeting register 0 stalls a consumer that reads register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read_i | input | 1 | Execute-stage instruction reads data memory (is a load) |
| ex_rt_i | input | REG_W | Destination register of the execute-stage load |
| id_rs_i | input | REG_W | First source register of the decode-stage instruction |
| id_rt_i | input | REG_W | Second source register of the decode-stage instruction |
| pc_we_o | output | 1 | Program counter write enable, 0 during a stall |
| ifid_we_o | output | 1 | Fetch/decode register write enable, 0 during a stall |
| ctrl_zero_o | output | 1 | 1 forces decode/execute control fields to zero |

## Verification
The bench sweeps every combination of read flag and the three register indices. This separates a match on the first source, a match on the second source, a match on both, no match, and a clear read flag that must mask any match. Index 0 is covered the same way, so an exclusion of register 0 would be caught. A small fetch/decode/execute register chain driven by the outputs then runs short programs. A load with a dependent consumer directly behind it must produce one bubble. A dependence two slots behind the load, loads with independent consumers, and a load-after-load chain show that no extra or missing stall cycles appear.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int LU_REG_W = 5;
  localparam int LU_N_SRC = 2;

  typedef enum logic {
    CTRL_PASS = 1'b0,
    CTRL_ZERO = 1'b1
  } ctrl_sel_e;
endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int REG_W = lu_pkg::LU_REG_W,
  parameter int N_SRC = lu_pkg::LU_N_SRC,
  localparam int SRC_W = REG_W * N_SRC
) (
  input  logic [REG_W-1:0] dst_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [N_SRC-1:0] hit_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign hit_o[g] = (src_i[g*REG_W +: REG_W] == dst_i);
  end
endmodule

// File: rtl/lu_stall_dec.sv
module lu_stall_dec #(
  parameter int N_SRC = lu_pkg::LU_N_SRC
) (
  input  logic             mem_read_i,
  input  logic [N_SRC-1:0] hit_i,
  output logic             stall_o
);
  assign stall_o = mem_read_i & (|hit_i);

  always_comb begin
    if (!mem_read_i) begin
      p_no_load_no_stall_r3: assert (!stall_o);
    end
    if (hit_i == '0) begin
      p_no_hit_no_stall_r4: assert (!stall_o);
    end
  end
endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_pkg::*;
#(
  parameter int REG_W = LU_REG_W
) (
  input  logic             ex_mem_read_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             ctrl_zero_o
);
  localparam int NS = LU_N_SRC;

  logic [NS-1:0] hit;
  logic          stall;
  ctrl_sel_e     sel;

  // source order: bit 0 = rs, bit 1 = rt
  lu_src_match #(.REG_W(REG_W), .N_SRC(NS)) i_match (
    .dst_i (ex_rt_i),
    .src_i ({id_rt_i, id_rs_i}),
    .hit_o (hit)
  );

  lu_stall_dec #(.N_SRC(NS)) i_dec (
    .mem_read_i (ex_mem_read_i),
    .hit_i      (hit),
    .stall_o    (stall)
  );

  assign sel         = stall ? CTRL_ZERO : CTRL_PASS;
  assign pc_we_o     = ~stall;
  assign ifid_we_o   = ~stall;
  assign ctrl_zero_o = (sel == CTRL_ZERO);

  always_comb begin
    p_we_pair_r5: assert (pc_we_o == ifid_we_o);
    p_sel_inv_r6: assert (ctrl_zero_o == !pc_we_o);
    if (ex_mem_read_i && (ex_rt_i == id_rs_i)) begin
      p_rs_stall_r1: assert (!pc_we_o && ctrl_zero_o);
    end
    if (ex_mem_read_i && (ex_rt_i == id_rt_i)) begin
      p_rt_stall_r2: assert (!ifid_we_o && ctrl_zero_o);
    end
  end
endmodule

// File: tb/test_lu_hazard_unit.sv
module test_lu_hazard_unit;
  localparam int W = 5;
  localparam int NR = 1 << W;

  logic         clk = 1'b0;
  logic         mr;
  logic [W-1:0] ert, irs, irt;
  logic         pc_we, ifid_we, czero;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  lu_hazard_unit #(.REG_W(W)) i_lu_hazard_unit (
    .ex_mem_read_i (mr),
    .ex_rt_i       (ert),
    .id_rs_i       (irs),
    .id_rt_i       (irt),
    .pc_we_o       (pc_we),
    .ifid_we_o     (ifid_we),
    .ctrl_zero_o   (czero)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (mr=%0d ex_rt=%0d rs=%0d rt=%0d)",
               req, act, exp, mr, ert, irs, irt);
    end
  endtask

  // instruction slot in the modelled chain
  typedef struct {
    bit       ld;
    bit [W-1:0] dst;
    bit [W-1:0] rs;
    bit [W-1:0] rt;
    bit       bub;
  } ins_t;

  ins_t prog[8];
  int   plen;

  task automatic run_prog(input string req, input int exp_bub);
    ins_t ifid, idex, nop;
    int pc, bubbles, retired;
    nop = '{ld:0, dst:0, rs:0, rt:0, bub:1};
    ifid = prog[0];
    pc = 1;
    idex = '{ld:0, dst:0, rs:0, rt:0, bub:0};
    bubbles = 0;
    retired = 0;
    for (int cyc = 0; cyc < 40 && retired < plen; cyc++) begin
      @(negedge clk);
      mr = idex.ld; ert = idex.dst; irs = ifid.rs; irt = ifid.rt;
      #1;
      @(posedge clk);
      if (czero) begin
        idex = nop;
        bubbles++;
      end else begin
        idex = ifid;
        retired++;
      end
      if (ifid_we) ifid = (pc < plen) ? prog[pc] : nop;
      if (pc_we) pc++;
    end
    chk({req, " bubbles"}, bubbles, exp_bub);
    chk({req, " all issued"}, retired, plen);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mr = 0; ert = 0; irs = 0; irt = 0;
    @(negedge clk); #1;
    chk("R3 idle pc_we", pc_we, 1);
    chk("R6 idle ctrl_zero", czero, 0);

    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < NR; e++) begin
        for (int s = 0; s < NR; s++) begin
          for (int t = 0; t < NR; t++) begin
            bit st;
            string rq;
            @(negedge clk);
            mr = m[0]; ert = e[W-1:0]; irs = s[W-1:0]; irt = t[W-1:0];
            #1;
            st = (m == 1) && (e == s || e == t);
            if (m == 0) rq = "R3";
            else if (e == s) rq = (e == 0) ? "R1 R8" : "R1";
            else if (e == t) rq = (e == 0) ? "R2 R8" : "R2";
            else rq = "R4";
            chk({rq, " R5 pc_we"}, pc_we, !st);
            chk({rq, " R5 ifid_we"}, ifid_we, !st);
            chk({rq, " R6 ctrl_zero"}, czero, st);
          end
        end
      end
    end

    // R7: load r3, consumer reads r3 as rs
    prog[0] = '{ld:1, dst:3, rs:2, rt:3, bub:0};
    prog[1] = '{ld:0, dst:4, rs:3, rt:5, bub:0};
    prog[2] = '{ld:0, dst:6, rs:3, rt:7, bub:0};
    plen = 3;
    run_prog("R7 dep-rs", 1);
    // R7: consumer reads load dst as rt
    prog[1] = '{ld:0, dst:4, rs:5, rt:3, bub:0};
    run_prog("R7 dep-rt", 1);
    // R7: independent consumers
    prog[1] = '{ld:0, dst:4, rs:5, rt:6, bub:0};
    prog[2] = '{ld:0, dst:6, rs:7, rt:8, bub:0};
    run_prog("R7 indep", 0);
    // R7: dependent two slots behind load
    prog[2] = '{ld:0, dst:6, rs:3, rt:3, bub:0};
    run_prog("R7 gap", 0);
    // R7: load chain, each load uses previous load result
    prog[0] = '{ld:1, dst:1, rs:2, rt:1, bub:0};
    prog[1] = '{ld:1, dst:9, rs:1, rt:9, bub:0};
    prog[2] = '{ld:0, dst:4, rs:9, rt:0, bub:0};
    prog[3] = '{ld:0, dst:5, rs:6, rt:7, bub:0};
    plen = 4;
    run_prog("R7 chain", 2);
    // R8: load to r0 followed by reader of r0
    prog[0] = '{ld:1, dst:0, rs:2, rt:0, bub:0};
    prog[1] = '{ld:0, dst:4, rs:0, rt:5, bub:0};
    plen = 2;
    run_prog("R8 r0 dep", 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule